// File: doc/BRIEF.md
# Burst-of-Two Separate-I/O SRAM Port

This block is a synthesizable model of a small synchronous static memory that has a write data bus and a read data bus of its own. Every access moves a burst of two beats. The two beats are timed by a complementary clock pair, `clk_k` and `clk_kn`. One read command and one write command can be accepted on each rising edge of `clk_k`, and they share a single address. Each address stores a two-beat word, beat 0 and beat 1, and every beat is split into byte lanes that can be written on their own.

A write command captures beat 0 and its lane enables on the rising edge of `clk_k`. It captures beat 1 and its own lane enables half a cycle later, on the rising edge of `clk_kn`. Either half of the burst can therefore be masked lane by lane. A read command presents beat 0 on the bus at the next rising edge of `clk_k`, and beat 1 half a cycle after that. When a slot carries no read data, the bus is marked as not driven for that slot. When a read and a write hit the same address in the same cycle, the read returns the word as it stood before that write.

Top module: `burst2_sram`

## Requirements
- R1: When `rd_n` is low at the rising edge of `clk_k` in cycle n, the stored beat 0 of `addr` appears on `dout` with `dout_oe` high while `clk_k` is high in cycle n+1. The stored beat 1 then appears with `dout_oe` high while `clk_k` is low, from the `clk_kn` rise of cycle n+1 until the next `clk_k` rise.
- R2: When `rd_n` is high at a `clk_k` rise, `dout_oe` is low and `dout` is all zeros in both beat slots of the following cycle.
- R3: When `wr_n` is low at a `clk_k` rise, every byte lane b whose `bwe_n[b]` is low at that edge stores `din[b*BYTE_W +: BYTE_W]` as that lane of beat 0 at `addr`.
- R4: For that same write, every lane whose `bwe_n[b]` is low at the following `clk_kn` rise stores the `din` lane sampled at that edge as that lane of beat 1 at the same address.
- R5: A lane whose `bwe_n` bit is high for a beat keeps its old value in that beat. The other lanes and the other beat are written as usual. A write with every enable high in both beats changes nothing.
- R6: When `wr_n` is high at a `clk_k` rise, no stored data changes, whatever `din` and `bwe_n` are doing.
- R7: A read and a write to the same address in the same cycle return the word stored before that write, for both beats.
- R8: A read issued in the cycle after a write to the same address returns the newly written beats.
- R9: While `rst_n` is low, and after it rises until the first read result is due, `dout_oe` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_k | input | 1 | Main clock; commands and beat 0 are sampled on its rise |
| clk_kn | input | 1 | Complement clock; beat 1 is sampled on its rise |
| rst_n | input | 1 | Asynchronous active-low reset of the command and output pipeline (not of the array) |
| rd_n | input | 1 | Read select, active low |
| wr_n | input | 1 | Write select, active low |
| addr | input | ADDR_W | Shared word address, sampled on `clk_k` rise |
| bwe_n | input | NBYTES | Per-lane write enables, active low, sampled on both clock rises |
| din | input | NBYTES*BYTE_W | Write data, beat 0 on `clk_k` rise, beat 1 on `clk_kn` rise |
| dout | output | NBYTES*BYTE_W | Read data, beat 0 while `clk_k` is high, beat 1 while it is low |
| dout_oe | output | 1 | High when `dout` carries read data in the current slot |

## Verification
A wrong pipeline flag shows as `dout_oe` rising or staying low in the wrong slot. It is visible at the first `clk_k` rise after the faulty command and lasts exactly one cycle. A corrupted lane enable or beat-1 address leaves no trace until that address is read back. For that reason, every partial or ignored write is followed by a read, and the result is compared lane by lane, beat by beat, against an independent reference array. The same-cycle read/write case tells an array updated too early from a correct one, because the old and new words differ in every lane.

// File: rtl/burst2_pkg.sv
package burst2_pkg;
  localparam int unsigned DEF_ADDR_W = 6;
  localparam int unsigned DEF_NBYTES = 2;
  localparam int unsigned DEF_BYTE_W = 9;

  // number of words for a given address width
  function automatic int unsigned depth_of(input int unsigned aw);
    return 1 << aw;
  endfunction
endpackage

// File: rtl/b2_bank.sv
// One beat's storage: a lane-maskable write port on its own clock and an
// asynchronous read port.
module b2_bank #(
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned NBYTES = 2,
  parameter int unsigned BYTE_W = 9
) (
  input  logic                     wclk,
  input  logic [NBYTES-1:0]        wen,
  input  logic [ADDR_W-1:0]        waddr,
  input  logic [NBYTES*BYTE_W-1:0] wdata,
  input  logic [ADDR_W-1:0]        raddr,
  output logic [NBYTES*BYTE_W-1:0] rdata
);
  localparam int unsigned W     = NBYTES * BYTE_W;
  localparam int unsigned DEPTH = burst2_pkg::depth_of(ADDR_W);

  logic [W-1:0] mem [DEPTH];

  // replace only the enabled lanes of the old word
  function automatic logic [W-1:0] merge_lanes(input logic [W-1:0] old_w,
                                               input logic [W-1:0] new_w,
                                               input logic [NBYTES-1:0] en);
    logic [W-1:0] r;
    r = old_w;
    for (int b = 0; b < NBYTES; b++)
      if (en[b]) r[b*BYTE_W +: BYTE_W] = new_w[b*BYTE_W +: BYTE_W];
    return r;
  endfunction

  always_ff @(posedge wclk) begin
    if (|wen) mem[waddr] <= merge_lanes(mem[waddr], wdata, wen);
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/b2_outpipe.sv
// Read pipeline: capture at command edge, launch beat 0 on the next clk_k rise,
// beat 1 on the following clk_kn rise, select by clk_k level.
module b2_outpipe #(
  parameter int unsigned W = 18
) (
  input  logic         clk_k,
  input  logic         clk_kn,
  input  logic         rst_n,
  input  logic         cap_oe,
  input  logic [W-1:0] cap_q0,
  input  logic [W-1:0] cap_q1,
  output logic         oe_k,
  output logic [W-1:0] q_k,
  output logic [W-1:0] dout,
  output logic         dout_oe
);
  logic         s_oe;
  logic [W-1:0] s_q0, s_q1, q1_hold, q_kn;
  logic         oe_kn;

  always_ff @(posedge clk_k or negedge rst_n) begin
    if (!rst_n) begin
      s_oe    <= 1'b0;
      s_q0    <= '0;
      s_q1    <= '0;
      oe_k    <= 1'b0;
      q_k     <= '0;
      q1_hold <= '0;
    end else begin
      s_oe    <= cap_oe;
      s_q0    <= cap_q0;
      s_q1    <= cap_q1;
      oe_k    <= s_oe;
      q_k     <= s_oe ? s_q0 : '0;
      q1_hold <= s_oe ? s_q1 : '0;
    end
  end

  always_ff @(posedge clk_kn or negedge rst_n) begin
    if (!rst_n) begin
      oe_kn <= 1'b0;
      q_kn  <= '0;
    end else begin
      oe_kn <= oe_k;
      q_kn  <= q1_hold;
    end
  end

  always_comb begin
    dout_oe = clk_k ? oe_k : oe_kn;
    dout    = clk_k ? q_k  : q_kn;
  end
endmodule

// File: rtl/burst2_sram.sv
module burst2_sram #(
  parameter int unsigned ADDR_W = burst2_pkg::DEF_ADDR_W,
  parameter int unsigned NBYTES = burst2_pkg::DEF_NBYTES,
  parameter int unsigned BYTE_W = burst2_pkg::DEF_BYTE_W
) (
  input  logic                     clk_k,
  input  logic                     clk_kn,
  input  logic                     rst_n,
  input  logic                     rd_n,
  input  logic                     wr_n,
  input  logic [ADDR_W-1:0]        addr,
  input  logic [NBYTES-1:0]        bwe_n,
  input  logic [NBYTES*BYTE_W-1:0] din,
  output logic [NBYTES*BYTE_W-1:0] dout,
  output logic                     dout_oe
);
  localparam int unsigned W = NBYTES * BYTE_W;

  // named internal events, also observed by the checker
  logic [NBYTES-1:0] b0_wen, b1_wen;
  logic              wr_pend;
  logic [ADDR_W-1:0] wr_addr;
  logic [W-1:0]      b0_rdata, b1_rdata, q_k;
  logic              oe_k;

  assign b0_wen = wr_n    ? '0 : ~bwe_n;
  assign b1_wen = wr_pend ? ~bwe_n : '0;

  // remember the write command for the half-cycle beat
  always_ff @(posedge clk_k or negedge rst_n) begin
    if (!rst_n) begin
      wr_pend <= 1'b0;
      wr_addr <= '0;
    end else begin
      wr_pend <= ~wr_n;
      wr_addr <= addr;
    end
  end

  b2_bank #(.ADDR_W(ADDR_W), .NBYTES(NBYTES), .BYTE_W(BYTE_W)) u_bank0 (
    .wclk(clk_k), .wen(b0_wen), .waddr(addr), .wdata(din),
    .raddr(addr), .rdata(b0_rdata)
  );

  b2_bank #(.ADDR_W(ADDR_W), .NBYTES(NBYTES), .BYTE_W(BYTE_W)) u_bank1 (
    .wclk(clk_kn), .wen(b1_wen), .waddr(wr_addr), .wdata(din),
    .raddr(addr), .rdata(b1_rdata)
  );

  b2_outpipe #(.W(W)) u_pipe (
    .clk_k(clk_k), .clk_kn(clk_kn), .rst_n(rst_n),
    .cap_oe(~rd_n), .cap_q0(b0_rdata), .cap_q1(b1_rdata),
    .oe_k(oe_k), .q_k(q_k), .dout(dout), .dout_oe(dout_oe)
  );
endmodule

// File: rtl/burst2_sram_chk.sv
module burst2_sram_chk #(
  parameter int unsigned W  = 18,
  parameter int unsigned NB = 2
) (
  input logic          clk_k,
  input logic          clk_kn,
  input logic          rst_n,
  input logic          rd_n,
  input logic          oe_k,
  input logic [W-1:0]  q_k,
  input logic [W-1:0]  b0_rdata,
  input logic          wr_pend,
  input logic [NB-1:0] b1_wen,
  input logic [W-1:0]  dout,
  input logic          dout_oe
);
  assert_read_slot_R1: assert property (@(posedge clk_k) disable iff (!rst_n)
    !rd_n |-> ##2 oe_k);

  assert_read_pre_write_R7: assert property (@(posedge clk_k) disable iff (!rst_n)
    !rd_n |-> ##2 (q_k == $past(b0_rdata, 2)));

  assert_idle_slot_R2: assert property (@(posedge clk_k) disable iff (!rst_n)
    rd_n |-> ##2 !oe_k);

  assert_quiet_bus_R2: assert property (@(negedge clk_k) disable iff (!rst_n)
    !dout_oe |-> (dout == '0));

  assert_no_stray_beat1_R6: assert property (@(posedge clk_kn) disable iff (!rst_n)
    !wr_pend |-> (b1_wen == '0));
endmodule

bind burst2_sram burst2_sram_chk #(.W(W), .NB(NBYTES)) u_chk (
  .clk_k(clk_k), .clk_kn(clk_kn), .rst_n(rst_n), .rd_n(rd_n),
  .oe_k(oe_k), .q_k(q_k), .b0_rdata(b0_rdata), .wr_pend(wr_pend),
  .b1_wen(b1_wen), .dout(dout), .dout_oe(dout_oe)
);

// File: tb/burst2_sram_test.sv
module burst2_sram_test;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 6;
  localparam int NB = 2;
  localparam int BW = 9;
  localparam int W  = NB * BW;
  localparam int DEPTH = 1 << AW;

  logic          clk_k, clk_kn, rst_n, rd_n, wr_n;
  logic [AW-1:0] addr;
  logic [NB-1:0] bwe_n;
  logic [W-1:0]  din, dout;
  logic          dout_oe;

  int n_run = 0, n_fail = 0;
  bit done = 0;

  logic [W-1:0] ref0 [DEPTH];
  logic [W-1:0] ref1 [DEPTH];
  logic         exp_oe = 1'b0;
  logic [W-1:0] exp_q0 = '0, exp_q1 = '0;
  string        exp_tag = "R9";

  burst2_sram uut (
    .clk_k(clk_k), .clk_kn(clk_kn), .rst_n(rst_n), .rd_n(rd_n), .wr_n(wr_n),
    .addr(addr), .bwe_n(bwe_n), .din(din), .dout(dout), .dout_oe(dout_oe)
  );

  initial begin
    clk_k = 1'b0;
    forever #(CLK_PERIOD/2) clk_k = ~clk_k;
  end
  assign clk_kn = ~clk_k;

  // lane b of a beat is bits [b*BW +: BW], replaced when its enable bit is 0
  function automatic logic [W-1:0] apply_lanes(input logic [W-1:0] cur,
                                               input logic [W-1:0] nw,
                                               input logic [NB-1:0] en_n);
    logic [W-1:0] r;
    r = cur;
    for (int b = 0; b < NB; b++)
      if (!en_n[b]) r[b*BW +: BW] = nw[b*BW +: BW];
    return r;
  endfunction

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [W-1:0] act, input logic [W-1:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic check_slot(input string what, input logic [W-1:0] exp_d);
    chk(dout_oe === exp_oe, exp_tag, {what, " oe"}, {{(W-1){1'b0}}, dout_oe},
        {{(W-1){1'b0}}, exp_oe});
    chk(dout === (exp_oe ? exp_d : '0), exp_tag, {what, " data"}, dout,
        exp_oe ? exp_d : '0);
  endtask

  // one command cycle; also checks the output of the previous command
  task automatic issue(input bit rd, input bit wr, input logic [AW-1:0] a,
                       input logic [NB-1:0] be0, input logic [W-1:0] d0,
                       input logic [NB-1:0] be1, input logic [W-1:0] d1,
                       input string tag);
    logic         n_oe;
    logic [W-1:0] n_q0, n_q1;
    rd_n = !rd; wr_n = !wr; addr = a; bwe_n = be0; din = d0;
    n_oe = rd; n_q0 = ref0[a]; n_q1 = ref1[a];
    if (wr) begin
      ref0[a] = apply_lanes(ref0[a], d0, be0);
      ref1[a] = apply_lanes(ref1[a], d1, be1);
    end
    @(posedge clk_k);
    #1 bwe_n = be1; din = d1;
    #1 check_slot("beat0", exp_q0);
    @(negedge clk_k);
    #2 check_slot("beat1", exp_q1);
    exp_oe = n_oe; exp_q0 = n_q0; exp_q1 = n_q1; exp_tag = tag;
  endtask

  task automatic idle(input string tag);
    issue(1'b0, 1'b0, '0, '1, '0, '1, '0, tag);
  endtask

  function automatic logic [W-1:0] pat0(input int a);
    return W'(a * 1031 + 7);
  endfunction
  function automatic logic [W-1:0] pat1(input int a);
    return W'(a * 517 + 99) ^ W'(18'h2AAAA);
  endfunction

  task automatic t_reset();
    #2;
    chk(dout_oe === 1'b0, "R9", "oe in reset", {{(W-1){1'b0}}, dout_oe}, '0);
    @(negedge clk_k); #2;
    chk(dout_oe === 1'b0, "R9", "oe in reset k-low", {{(W-1){1'b0}}, dout_oe}, '0);
  endtask

  task automatic t_fill();  // R3 R4, reads deselected -> R2
    for (int a = 0; a < DEPTH; a++)
      issue(1'b0, 1'b1, AW'(a), '0, pat0(a), '0, pat1(a), "R2");
    idle("R2");
  endtask

  task automatic t_readall();  // R1 R3 R4
    for (int a = 0; a < DEPTH; a++)
      issue(1'b1, 1'b0, AW'(a), '1, '0, '1, '0, "R1");
    idle("R1");
  endtask

  task automatic t_partial();  // R5
    issue(1'b0, 1'b1, 6'd5, 2'b10, 18'h3FFFF, 2'b01, 18'h15555, "R5");
    issue(1'b0, 1'b1, 6'd6, 2'b11, 18'h11111, 2'b00, 18'h22222, "R5");
    issue(1'b0, 1'b1, 6'd8, 2'b01, 18'h0F0F0, 2'b11, 18'h33333, "R5");
    issue(1'b0, 1'b1, 6'd10, 2'b11, 18'h12345, 2'b11, 18'h23456, "R5");
    issue(1'b1, 1'b0, 6'd5, '1, '0, '1, '0, "R5");
    issue(1'b1, 1'b0, 6'd6, '1, '0, '1, '0, "R5");
    issue(1'b1, 1'b0, 6'd8, '1, '0, '1, '0, "R5");
    issue(1'b1, 1'b0, 6'd10, '1, '0, '1, '0, "R5");
    idle("R5");
  endtask

  task automatic t_nowrite();  // R6: enables low, data driven, wr_n high
    issue(1'b0, 1'b0, 6'd7, 2'b00, 18'h3FFFF, 2'b00, 18'h3FFFF, "R6");
    issue(1'b0, 1'b0, 6'd11, 2'b00, 18'h00000, 2'b00, 18'h00000, "R6");
    issue(1'b1, 1'b0, 6'd7, '1, '0, '1, '0, "R6");
    issue(1'b1, 1'b0, 6'd11, '1, '0, '1, '0, "R6");
    idle("R6");
  endtask

  task automatic t_same_cycle();  // R7 then R8
    issue(1'b1, 1'b1, 6'd9, 2'b00, ~pat0(9), 2'b00, ~pat1(9), "R7");
    issue(1'b1, 1'b0, 6'd9, '1, '0, '1, '0, "R8");
    issue(1'b1, 1'b1, 6'd12, 2'b00, 18'h2468A, 2'b00, 18'h13579, "R7");
    issue(1'b1, 1'b1, 6'd12, 2'b10, 18'h00001, 2'b01, 18'h3FE00, "R8");
    issue(1'b1, 1'b0, 6'd12, '1, '0, '1, '0, "R8");
    idle("R8");
  endtask

  task automatic t_mixed();  // R1 R2 alternating slots
    issue(1'b1, 1'b0, 6'd63, '1, '0, '1, '0, "R1");
    issue(1'b0, 1'b0, 6'd1, '1, '0, '1, '0, "R2");
    issue(1'b1, 1'b0, 6'd0, '1, '0, '1, '0, "R1");
    issue(1'b1, 1'b0, 6'd62, '1, '0, '1, '0, "R1");
    issue(1'b0, 1'b0, 6'd2, '1, '0, '1, '0, "R2");
    idle("R2");
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_run++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; rd_n = 1'b1; wr_n = 1'b1; addr = '0; bwe_n = '1; din = '0;
    for (int a = 0; a < DEPTH; a++) begin ref0[a] = '0; ref1[a] = '0; end
    t_reset();
    repeat (2) @(posedge clk_k);
    @(negedge clk_k); #2 rst_n = 1'b1;
    @(negedge clk_k); #2;
    t_fill();
    t_readall();
    t_partial();
    t_nowrite();
    t_same_cycle();
    t_mixed();
    finish_run();
  end
endmodule